// File: doc/BRIEF.md
# Segment-Override and Addressing-Byte Parser

This block sits at the front of an instruction decoder for a 16-bit segmented processor. It accepts instruction bytes one per cycle from a valid-qualified byte stream and walks through an instruction's leading bytes. These are up to two segment-override prefix bytes, then the opcode, then (for opcodes marked as using one) the addressing byte, and then zero, one or two displacement bytes.

When the last addressing byte has been taken, the block presents a parsed record for one cycle. The record holds:
- the opcode with its direction and width bits,
- the three fields of the addressing byte,
- the displacement, assembled and widened to 16 bits,
- the override flag and its two-bit segment code.

A caller sets `has_modrm` alongside each opcode byte to say whether an addressing byte follows. Immediate operands and the rest of opcode decoding belong to later stages.

Top module: `seg_modrm_parser`

## Requirements
- R1: A synchronous reset clears `rec_valid` and `pfx_err`, zeroes every record output, and discards any partial instruction and pending override, so the next byte is treated as a prefix or opcode. `in_ready` is always 1.
- R2: In the prefix/opcode state, a byte whose bits 7:5 are 001 and bits 2:0 are 110 is an override prefix with segment code equal to bits 4:3 (0x26, 0x2E, 0x36, 0x3E give 0, 1, 2, 3). A record preceded by at least one prefix carries `rec_ovr_valid`=1 and that code. Without a prefix it carries `rec_ovr_valid`=0 and `rec_ovr_seg`=0.
- R3: With two prefixes before the opcode, the segment code of the second one is reported.
- R4: A third consecutive prefix byte pulses `pfx_err` for one cycle, produces no record, and drops the pending override, so the next opcode's record has `rec_ovr_valid`=0.
- R5: `rec_opcode` is the full opcode byte. `rec_dir` is its bit 1 (1 = REG field is the destination) and `rec_wide` is its bit 0 (1 = word operands).
- R6: If `has_modrm` is 0 together with the opcode byte, the record is emitted right after the opcode with mode, reg, r/m and displacement all zero.
- R7: The addressing byte is split as `rec_mod` = bits 7:6, `rec_reg` = bits 5:3 and `rec_rm` = bits 2:0.
- R8: The number of displacement bytes is 0 for mode 00, 1 for mode 01, 2 for mode 10 and 0 for mode 11, except that mode 00 with r/m 110 takes 2. With no displacement bytes, `rec_disp` is 0.
- R9: A two-byte displacement arrives low byte first; `rec_disp` = {second byte, first byte}.
- R10: A one-byte displacement is sign-extended to 16 bits in `rec_disp`.
- R11: `rec_valid` is high for exactly the one cycle after the instruction's final byte is accepted. Bytes with `in_valid` low are ignored, so idle cycles may be inserted between any two bytes.
- R12: Override state is cleared after every record, so an instruction without prefixes never inherits the previous instruction's override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_byte` is offered this cycle |
| in_byte | input | 8 | Instruction stream byte |
| has_modrm | input | 1 | With an opcode byte: an addressing byte follows |
| in_ready | output | 1 | Always 1; every valid byte is taken |
| rec_valid | output | 1 | One-cycle pulse: record fields are valid |
| rec_opcode | output | 8 | Opcode byte |
| rec_dir | output | 1 | Direction bit of the opcode |
| rec_wide | output | 1 | Width bit of the opcode |
| rec_mod | output | 2 | Mode field |
| rec_reg | output | 3 | Register field |
| rec_rm | output | 3 | Register/memory field |
| rec_disp | output | 16 | Displacement, widened to 16 bits |
| rec_ovr_valid | output | 1 | A segment override was given |
| rec_ovr_seg | output | 2 | Segment code of the override |
| pfx_err | output | 1 | One-cycle pulse on a third prefix byte |

## Verification
Every one of the 256 addressing-byte values is sent with an opcode. This separates the zero-, one- and two-byte displacement cases, including the direct-address exception. The displacement low byte is varied so that both signs of the one-byte form are covered. The prefix count cycles through none, one and two, with all four segment codes in both positions, which tells last-wins apart from first-wins and shows whether override state leaks into the next instruction. Idle cycles that carry prefix-looking bytes with `in_valid` low show that unqualified bytes are ignored. A sweep of opcodes with no addressing byte checks the short path and the direction and width bits. A third-prefix case and a mid-instruction reset each check that parsing restarts cleanly.

// File: rtl/seg_modrm_parser.sv
module seg_modrm_parser #(
  parameter int MAX_PFX = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        has_modrm,
  output logic        in_ready,
  output logic        rec_valid,
  output logic [7:0]  rec_opcode,
  output logic        rec_dir,
  output logic        rec_wide,
  output logic [1:0]  rec_mod,
  output logic [2:0]  rec_reg,
  output logic [2:0]  rec_rm,
  output logic [15:0] rec_disp,
  output logic        rec_ovr_valid,
  output logic [1:0]  rec_ovr_seg,
  output logic        pfx_err
);
  localparam int CW = $clog2(MAX_PFX + 1);

  typedef enum logic [1:0] {ST_HEAD, ST_MODRM, ST_DLO, ST_DHI} st_t;

  st_t         st;
  logic [CW-1:0] pcnt;
  logic        ov_v;
  logic [1:0]  ov_seg;
  logic [7:0]  op_q;
  logic [1:0]  mod_q;
  logic [2:0]  reg_q, rm_q;
  logic [7:0]  lo_q;

  logic        is_pfx;
  logic [1:0]  ndisp;
  logic        fin;
  logic [7:0]  f_op;
  logic [1:0]  f_mod;
  logic [2:0]  f_reg, f_rm;
  logic [15:0] f_disp;

  assign in_ready = 1'b1;
  assign rec_dir  = rec_opcode[1];
  assign rec_wide = rec_opcode[0];

  assign is_pfx = (in_byte[7:5] == 3'b001) && (in_byte[2:0] == 3'b110);
  assign ndisp  = (in_byte[7:6] == 2'b01) ? 2'd1 :
                  ((in_byte[7:6] == 2'b10) ||
                   (in_byte[7:6] == 2'b00 && in_byte[2:0] == 3'b110)) ? 2'd2 : 2'd0;

  always_comb begin
    fin    = 1'b0;
    f_op   = op_q;
    f_mod  = mod_q;
    f_reg  = reg_q;
    f_rm   = rm_q;
    f_disp = '0;
    case (st)
      ST_HEAD: begin
        fin   = in_valid && !is_pfx && !has_modrm;
        f_op  = in_byte;
        f_mod = '0;
        f_reg = '0;
        f_rm  = '0;
      end
      ST_MODRM: begin
        fin   = in_valid && (ndisp == 2'd0);
        f_mod = in_byte[7:6];
        f_reg = in_byte[5:3];
        f_rm  = in_byte[2:0];
      end
      ST_DLO: begin
        fin    = in_valid && (mod_q == 2'b01);
        f_disp = {{8{in_byte[7]}}, in_byte};
      end
      default: begin
        fin    = in_valid;
        f_disp = {in_byte, lo_q};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_HEAD;
      pcnt          <= '0;
      ov_v          <= 1'b0;
      ov_seg        <= 2'b00;
      op_q          <= '0;
      mod_q         <= '0;
      reg_q         <= '0;
      rm_q          <= '0;
      lo_q          <= '0;
      rec_valid     <= 1'b0;
      pfx_err       <= 1'b0;
      rec_opcode    <= '0;
      rec_mod       <= '0;
      rec_reg       <= '0;
      rec_rm        <= '0;
      rec_disp      <= '0;
      rec_ovr_valid <= 1'b0;
      rec_ovr_seg   <= 2'b00;
    end else begin
      rec_valid <= 1'b0;
      pfx_err   <= 1'b0;
      if (in_valid) begin
        case (st)
          ST_HEAD: begin
            if (is_pfx) begin
              if (pcnt == CW'(MAX_PFX)) begin
                pfx_err <= 1'b1;
                pcnt    <= '0;
                ov_v    <= 1'b0;
                ov_seg  <= 2'b00;
              end else begin
                pcnt   <= pcnt + 1'b1;
                ov_v   <= 1'b1;
                ov_seg <= in_byte[4:3];
              end
            end else begin
              op_q <= in_byte;
              if (has_modrm) st <= ST_MODRM;
            end
          end
          ST_MODRM: begin
            mod_q <= in_byte[7:6];
            reg_q <= in_byte[5:3];
            rm_q  <= in_byte[2:0];
            if (ndisp != 2'd0) st <= ST_DLO;
          end
          ST_DLO: begin
            lo_q <= in_byte;
            if (mod_q != 2'b01) st <= ST_DHI;
          end
          default: ;
        endcase
      end
      if (fin) begin
        rec_valid     <= 1'b1;
        rec_opcode    <= f_op;
        rec_mod       <= f_mod;
        rec_reg       <= f_reg;
        rec_rm        <= f_rm;
        rec_disp      <= f_disp;
        rec_ovr_valid <= ov_v;
        rec_ovr_seg   <= ov_v ? ov_seg : 2'b00;
        pcnt          <= '0;
        ov_v          <= 1'b0;
        ov_seg        <= 2'b00;
        st            <= ST_HEAD;
      end
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid && pfx_err));
  p_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
    pfx_err |-> $past(in_valid && is_pfx && st == ST_HEAD));
  p_pcnt_r3: assert property (@(posedge clk) disable iff (rst)
    pcnt <= CW'(MAX_PFX));
  p_sext_r10: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_mod == 2'b01) |-> (rec_disp[15:8] == {8{rec_disp[7]}}));
  p_nodisp_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && (rec_mod == 2'b11 || (rec_mod == 2'b00 && rec_rm != 3'b110)))
      |-> (rec_disp == 16'h0000));
  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(in_valid));
  p_noseg_r2: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ovr_valid) |-> (rec_ovr_seg == 2'b00));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (!ov_v && pcnt == '0 && st == ST_HEAD));
endmodule

// File: tb/seg_modrm_parser_tb.sv
module seg_modrm_parser_tb;
  logic        clk = 1'b0;
  logic        rst, in_valid, has_modrm;
  logic [7:0]  in_byte;
  logic        in_ready, rec_valid, rec_dir, rec_wide, rec_ovr_valid, pfx_err;
  logic [7:0]  rec_opcode;
  logic [1:0]  rec_mod, rec_ovr_seg;
  logic [2:0]  rec_reg, rec_rm;
  logic [15:0] rec_disp;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  seg_modrm_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .has_modrm(has_modrm), .in_ready(in_ready), .rec_valid(rec_valid),
    .rec_opcode(rec_opcode), .rec_dir(rec_dir), .rec_wide(rec_wide),
    .rec_mod(rec_mod), .rec_reg(rec_reg), .rec_rm(rec_rm),
    .rec_disp(rec_disp), .rec_ovr_valid(rec_ovr_valid),
    .rec_ovr_seg(rec_ovr_seg), .pfx_err(pfx_err)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, logic hm, bit gap);
    if (gap) begin
      in_valid  = 1'b0;
      in_byte   = 8'h3E;
      has_modrm = 1'b1;
      @(negedge clk);
      chk(!rec_valid && !pfx_err, "R11 idle", {rec_valid, pfx_err}, 0);
    end
    in_valid  = 1'b1;
    in_byte   = b;
    has_modrm = hm;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic run_instr(int npfx, logic [7:0] p0, logic [7:0] p1,
                           logic [7:0] opc, logic hm, logic [7:0] mrm,
                           logic [7:0] dlo, logic [7:0] dhi, bit gap);
    int nd;
    logic [15:0] ed;
    logic [1:0] es;
    if (npfx >= 1) begin
      put(p0, 1'b0, gap);
      chk(!rec_valid && !pfx_err, "R2 prefix", {rec_valid, pfx_err}, 0);
    end
    if (npfx == 2) begin
      put(p1, 1'b1, gap);
      chk(!rec_valid && !pfx_err, "R3 prefix", {rec_valid, pfx_err}, 0);
    end
    es = (npfx == 2) ? p1[4:3] : (npfx == 1) ? p0[4:3] : 2'b00;
    put(opc, hm, gap);
    nd = 0;
    ed = 16'h0000;
    if (hm) begin
      chk(!rec_valid, "R11 early", rec_valid, 0);
      put(mrm, 1'b0, gap);
      if (mrm[7:6] == 2'b01) nd = 1;
      else if (mrm[7:6] == 2'b10 || (mrm[7:6] == 2'b00 && mrm[2:0] == 3'b110)) nd = 2;
      if (nd >= 1) begin
        chk(!rec_valid, "R8 early", rec_valid, 0);
        put(dlo, 1'b0, gap);
      end
      if (nd == 2) begin
        chk(!rec_valid, "R9 early", rec_valid, 0);
        put(dhi, 1'b1, gap);
      end
      if (nd == 1) ed = {{8{dlo[7]}}, dlo};
      if (nd == 2) ed = {dhi, dlo};
    end
    chk(rec_valid === 1'b1, "R11 valid", rec_valid, 1);
    chk(rec_opcode === opc, "R5 opcode", rec_opcode, opc);
    chk(rec_dir === opc[1] && rec_wide === opc[0], "R5 dir/wide",
        {rec_dir, rec_wide}, opc[1:0]);
    if (hm)
      chk({rec_mod, rec_reg, rec_rm} === mrm, "R7 fields",
          {rec_mod, rec_reg, rec_rm}, mrm);
    else
      chk({rec_mod, rec_reg, rec_rm} === 8'h00 && rec_disp === 16'h0, "R6 no modrm",
          {rec_mod, rec_reg, rec_rm, rec_disp}, 0);
    if (nd == 1)      chk(rec_disp === ed, "R10 disp8", rec_disp, ed);
    else if (nd == 2) chk(rec_disp === ed, "R9 disp16", rec_disp, ed);
    else              chk(rec_disp === ed, "R8 nodisp", rec_disp, ed);
    if (npfx == 0)
      chk(rec_ovr_valid === 1'b0 && rec_ovr_seg === 2'b00, "R12 no override",
          {rec_ovr_valid, rec_ovr_seg}, 0);
    else
      chk(rec_ovr_valid === 1'b1 && rec_ovr_seg === es,
          (npfx == 2) ? "R3 last wins" : "R2 override",
          {rec_ovr_valid, rec_ovr_seg}, {1'b1, es});
    in_valid = 1'b0;
    @(negedge clk);
    chk(!rec_valid, "R11 pulse", rec_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] opc;
    rst = 1'b1;
    in_valid = 1'b0;
    in_byte = 8'h00;
    has_modrm = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rec_valid && !pfx_err && in_ready && rec_disp == 0 && rec_opcode == 0
        && !rec_ovr_valid, "R1 reset", {rec_valid, pfx_err, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 256; m++) begin
      opc = 8'((m * 37 + 1) & 8'hFF);
      if ((opc & 8'hE7) == 8'h26) opc = opc ^ 8'h01;
      run_instr(m % 3, 8'h26 | 8'((m % 4) << 3), 8'h26 | 8'(((m >> 2) % 4) << 3),
                opc, 1'b1, 8'(m), 8'((m * 7 + 8'h80) & 8'hFF), ~8'(m), (m % 5) == 0);
    end

    for (int k = 0; k < 64; k++) begin
      opc = 8'(k * 4 + (k % 4));
      if ((opc & 8'hE7) == 8'h26) opc = opc ^ 8'h01;
      run_instr(k % 3, 8'h2E, 8'h36 | 8'((k % 2) << 3), opc, 1'b0, 8'hFF, 8'h00, 8'h00, (k % 7) == 0);
    end

    put(8'h26, 1'b0, 1'b0);
    put(8'h2E, 1'b0, 1'b0);
    put(8'h3E, 1'b0, 1'b0);
    chk(pfx_err === 1'b1 && !rec_valid, "R4 third prefix", {pfx_err, rec_valid}, 2'b10);
    @(negedge clk);
    chk(!pfx_err, "R4 pulse", pfx_err, 0);
    put(8'h8B, 1'b0, 1'b0);
    chk(rec_valid && !rec_ovr_valid && rec_ovr_seg == 0, "R4 override dropped",
        {rec_valid, rec_ovr_valid, rec_ovr_seg}, 4'b1000);
    @(negedge clk);

    put(8'h36, 1'b0, 1'b0);
    put(8'h8B, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(!rec_valid && !pfx_err && rec_opcode == 0, "R1 reset mid-parse",
        {rec_valid, pfx_err, rec_opcode}, 0);
    rst = 1'b0;
    put(8'h90, 1'b0, 1'b0);
    chk(rec_valid && rec_opcode == 8'h90 && !rec_ovr_valid, "R1 restart",
        {rec_valid, rec_opcode, rec_ovr_valid}, {1'b1, 8'h90, 1'b0});
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule